// File: doc/BRIEF.md
# Dual-View GPIO Port Register File

This block holds the configuration and output state of one GPIO port of up to eight pins. Software reaches the same flops in two ways. In the attribute-wide view, one register covers one attribute, such as output data or slew, and holds one bit for each pin, so a single write can retarget many pins. In the per-pin view, one register covers one pin and packs seven of its attribute bits together with its live input state, so a single write fully reconfigures that pin. Both views decode onto the same storage, so a change made through either view is seen by the other at once.

The block has two independent write channels, A and B, and one combinational read port. Each pin's stored state drives the pad controls for that pin: output data, an effective 3-bit drive mode, a slow-edge select and an input-buffer disable. When a pin's bidirectional enable is set, one line of a 16-line auxiliary output-enable bus, chosen per pin, decides whether the pin uses its configured drive mode or falls back to the high-impedance code. The pin state that software reads is the pad input, forced to 0 while that pin's input buffer is disabled.

Top module: `gpio_dual_view_regs`

## Requirements
- R1: Reset clears every stored bit, including the output-enable selectors. Every pin then has effective drive mode 0, the high-impedance input code, and every register reads 0 apart from the pin-state bits.
- R2: In the attribute-wide view, addresses 0 to 6 hold these attributes: 0 data out, 1 to 3 drive-mode bits 0 to 2, 4 slow edge, 5 input disable, 6 bidirectional enable. Bit p of each register belongs to pin p.
- R3: In the per-pin view, address 16+p is the register of pin p. Its bit 0 is data out, bits 3:1 are the drive mode, bit 4 is slow edge, bit 5 is input disable, bit 6 is bidirectional enable and bit 7 is the pin state. A write there changes only pin p.
- R4: A write through either view can be read through the other view in the next cycle.
- R5: Each pin has a 4-bit selector of an auxiliary line. The selector of pin p sits in the register at address 8+p/2: pins with an even index use bits 3:0 and pins with an odd index use bits 7:4.
- R6: When a pin's bidirectional enable is 0, its effective drive mode equals its stored mode. When the enable is 1, the effective drive mode equals the stored mode while the selected auxiliary line is 1, and is 0 while that line is 0.
- R7: Address 7 and bit 7 of each per-pin register read the pad input ANDed with the inverse of that pin's input disable. Writes to these bits have no effect.
- R8: When a per-pin write and an attribute-wide write land in the same cycle, the per-pin write sets every attribute bit of its own pin. The other pins take the attribute-wide write.
- R9: When both channels write the same kind of register in the same cycle, channel B's data is kept wherever the two writes overlap.
- R10: Addresses 12 to 15 and 24 to 31 read 0, and writes to them change nothing.
- R11: The data out, slow edge and input disable outputs follow each pin's stored bits directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_we | input | 1 | Write strobe of channel A |
| a_addr | input | 5 | Write address of channel A |
| a_wdata | input | 8 | Write data of channel A |
| b_we | input | 1 | Write strobe of channel B |
| b_addr | input | 5 | Write address of channel B |
| b_wdata | input | 8 | Write data of channel B |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Combinational read data |
| pad_in | input | 8 | Pad input levels |
| aux_oe | input | 16 | Auxiliary output-enable lines |
| pad_out | output | 8 | Output data per pin |
| pad_mode | output | 24 | Effective drive mode, 3 bits per pin |
| pad_slow | output | 8 | Slow edge select per pin |
| pad_in_dis | output | 8 | Input buffer disable per pin |

## Verification
The bench uses the default build: eight pins and sixteen auxiliary lines. With these values every selector is a full 4-bit field and two selectors share each selector register, so the nibble placement of both even and odd pins is tested, as is routing from high-numbered lines such as line 10. Eight pins also fill the attribute-wide registers completely, which makes pin 7 the edge case for the bit mapping and for the collision checks between the two channels.

// File: rtl/gpio_dv_pkg.sv
package gpio_dv_pkg;
   localparam int ADDR_W       = 5;
   localparam int DATA_W       = 8;
   localparam int ATTR_W       = 7;
   localparam int MODE_W       = 3;
   localparam int A_DOUT       = 0;
   localparam int A_MODE       = 1;
   localparam int A_SLOW       = 4;
   localparam int A_IDIS       = 5;
   localparam int A_BIDIR      = 6;
   localparam int STATE_ADDR   = 7;
   localparam int SEL_BASE     = 8;
   localparam int PIN_BASE     = 16;
   localparam logic [MODE_W-1:0] MODE_HIZ = '0;

   function automatic int sel_field_w(input int lines);
      int w;
      w = $clog2(lines);
      if (w <= 1) return 1;
      else if (w <= 2) return 2;
      else return 4;
   endfunction
endpackage

// File: rtl/gpio_dv_pin_cell.sv
module gpio_dv_pin_cell
   import gpio_dv_pkg::*;
#(
   parameter int PIN   = 0,
   parameter int SEL_FW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 a_we,
   input  logic [ADDR_W-1:0]    a_addr,
   input  logic [DATA_W-1:0]    a_wdata,
   input  logic                 b_we,
   input  logic [ADDR_W-1:0]    b_addr,
   input  logic [DATA_W-1:0]    b_wdata,
   output logic [ATTR_W-1:0]    attr_q,
   output logic [SEL_FW-1:0]    sel_q
);
   localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(PIN_BASE + PIN);
   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_BASE + (PIN * SEL_FW) / DATA_W);
   localparam int                SEL_LSB  = (PIN * SEL_FW) % DATA_W;

   logic [ATTR_W-1:0] attr_d;
   logic [SEL_FW-1:0] sel_d;

   always_comb begin
      attr_d = attr_q;
      sel_d  = sel_q;
      for (int i = 0; i < ATTR_W; i++) begin
         if (a_we && a_addr == ADDR_W'(i)) attr_d[i] = a_wdata[PIN];
         if (b_we && b_addr == ADDR_W'(i)) attr_d[i] = b_wdata[PIN];
      end
      if (a_we && a_addr == PIN_ADDR) attr_d = a_wdata[ATTR_W-1:0];
      if (b_we && b_addr == PIN_ADDR) attr_d = b_wdata[ATTR_W-1:0];
      if (a_we && a_addr == SEL_ADDR) sel_d = a_wdata[SEL_LSB +: SEL_FW];
      if (b_we && b_addr == SEL_ADDR) sel_d = b_wdata[SEL_LSB +: SEL_FW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr_q <= '0;
         sel_q  <= '0;
      end else begin
         attr_q <= attr_d;
         sel_q  <= sel_d;
      end
   end

   // R1: state is clear on the first edge after reset release
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (attr_q == '0 && sel_q == '0));

   // R3: a channel-B per-pin write always lands whole
   a_r3_pin_write_b: assert property (@(posedge clk) disable iff (!rst_n)
      (b_we && b_addr == PIN_ADDR) |=> (attr_q == $past(b_wdata[ATTR_W-1:0])));

   // R8: a channel-A per-pin write beats any attribute-wide write of channel B
   a_r8_pin_over_port: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we && a_addr == PIN_ADDR && !(b_we && b_addr == PIN_ADDR))
      |=> (attr_q == $past(a_wdata[ATTR_W-1:0])));

   // R10: no strobe, no change
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_we && !b_we) |=> ($stable(attr_q) && $stable(sel_q)));
endmodule

// File: rtl/gpio_dv_read_mux.sv
module gpio_dv_read_mux
   import gpio_dv_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int SEL_FW   = 4
) (
   input  logic [ADDR_W-1:0]          rd_addr,
   input  logic [NUM_PINS*ATTR_W-1:0] attr_flat,
   input  logic [NUM_PINS*SEL_FW-1:0] sel_flat,
   input  logic [NUM_PINS-1:0]        pin_state,
   output logic [DATA_W-1:0]          rd_data
);
   localparam int SEL_REGS = (NUM_PINS * SEL_FW + DATA_W - 1) / DATA_W;

   logic [SEL_REGS*DATA_W-1:0] sel_pad;

   always_comb begin
      sel_pad = '0;
      sel_pad[NUM_PINS*SEL_FW-1:0] = sel_flat;
   end

   always_comb begin
      rd_data = '0;
      for (int a = 0; a < ATTR_W; a++) begin
         if (rd_addr == ADDR_W'(a)) begin
            for (int p = 0; p < NUM_PINS; p++) rd_data[p] = attr_flat[p*ATTR_W + a];
         end
      end
      if (rd_addr == ADDR_W'(STATE_ADDR)) rd_data[NUM_PINS-1:0] = pin_state;
      for (int r = 0; r < SEL_REGS; r++) begin
         if (rd_addr == ADDR_W'(SEL_BASE + r)) rd_data = sel_pad[r*DATA_W +: DATA_W];
      end
      for (int p = 0; p < NUM_PINS; p++) begin
         if (rd_addr == ADDR_W'(PIN_BASE + p))
            rd_data = {pin_state[p], attr_flat[p*ATTR_W +: ATTR_W]};
      end
   end
endmodule

// File: rtl/gpio_dual_view_regs.sv
module gpio_dual_view_regs
   import gpio_dv_pkg::*;
#(
   parameter int NUM_PINS  = 8,
   parameter int AUX_LINES = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       a_we,
   input  logic [ADDR_W-1:0]          a_addr,
   input  logic [DATA_W-1:0]          a_wdata,
   input  logic                       b_we,
   input  logic [ADDR_W-1:0]          b_addr,
   input  logic [DATA_W-1:0]          b_wdata,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [NUM_PINS-1:0]        pad_in,
   input  logic [AUX_LINES-1:0]       aux_oe,
   output logic [NUM_PINS-1:0]        pad_out,
   output logic [NUM_PINS*MODE_W-1:0] pad_mode,
   output logic [NUM_PINS-1:0]        pad_slow,
   output logic [NUM_PINS-1:0]        pad_in_dis
);
   localparam int SEL_W  = $clog2(AUX_LINES);
   localparam int SEL_FW = sel_field_w(AUX_LINES);

   generate
      if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
         $error("NUM_PINS must lie in 1..8");
      end
      if (AUX_LINES < 2 || AUX_LINES > 16 || (AUX_LINES & (AUX_LINES - 1)) != 0) begin : g_bad_aux
         $error("AUX_LINES must be a power of two in 2..16");
      end
   endgenerate

   logic [NUM_PINS*ATTR_W-1:0] attr_flat;
   logic [NUM_PINS*SEL_FW-1:0] sel_flat;
   logic [NUM_PINS-1:0]        pin_state;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [ATTR_W-1:0] attr;
      logic [SEL_FW-1:0] sel;
      logic              oe;

      gpio_dv_pin_cell #(.PIN(p), .SEL_FW(SEL_FW)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .a_we    (a_we),
         .a_addr  (a_addr),
         .a_wdata (a_wdata),
         .b_we    (b_we),
         .b_addr  (b_addr),
         .b_wdata (b_wdata),
         .attr_q  (attr),
         .sel_q   (sel)
      );

      assign attr_flat[p*ATTR_W +: ATTR_W] = attr;
      assign sel_flat[p*SEL_FW +: SEL_FW]  = sel;
      assign oe = attr[A_BIDIR] ? aux_oe[sel[SEL_W-1:0]] : 1'b1;
      assign pad_mode[p*MODE_W +: MODE_W] = oe ? attr[A_MODE +: MODE_W] : MODE_HIZ;
      assign pad_out[p]    = attr[A_DOUT];
      assign pad_slow[p]   = attr[A_SLOW];
      assign pad_in_dis[p] = attr[A_IDIS];
      assign pin_state[p]  = pad_in[p] & ~attr[A_IDIS];

      // R6: bidirectional pin with its line low must present high impedance
      a_r6_bidir_hiz: assert property (@(posedge clk) disable iff (!rst_n)
         (attr[A_BIDIR] && !aux_oe[sel[SEL_W-1:0]])
         |-> (pad_mode[p*MODE_W +: MODE_W] == MODE_HIZ));

      // R7: a disabled input buffer reads as 0 through the state register
      a_r7_state_gated: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_addr == ADDR_W'(STATE_ADDR) && pad_in_dis[p]) |-> !rd_data[p]);
   end

   gpio_dv_read_mux #(.NUM_PINS(NUM_PINS), .SEL_FW(SEL_FW)) u_rd (
      .rd_addr   (rd_addr),
      .attr_flat (attr_flat),
      .sel_flat  (sel_flat),
      .pin_state (pin_state),
      .rd_data   (rd_data)
   );
endmodule

// File: tb/gpio_dual_view_regs_test.sv
module gpio_dual_view_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_we = 1'b0, b_we = 1'b0;
   logic [4:0]  a_addr = '0, b_addr = '0, rd_addr = '0;
   logic [7:0]  a_wdata = '0, b_wdata = '0;
   logic [7:0]  rd_data;
   logic [7:0]  pad_in = 8'hA5;
   logic [15:0] aux_oe = '0;
   logic [7:0]  pad_out, pad_slow, pad_in_dis;
   logic [23:0] pad_mode;
   int checks = 0, failures = 0, cycles = 0;

   always #10 clk = ~clk;

   gpio_dual_view_regs uut (
      .clk(clk), .rst_n(rst_n),
      .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
      .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pad_in(pad_in), .aux_oe(aux_oe),
      .pad_out(pad_out), .pad_mode(pad_mode),
      .pad_slow(pad_slow), .pad_in_dis(pad_in_dis)
   );

   // {write addr, write data, read addr, expected read}, applied in order
   localparam logic [25:0] VEC [14] = '{
      {5'd0,  8'h3C, 5'd16, 8'h80},  // R2 R3 R7
      {5'd1,  8'hFF, 5'd18, 8'h83},  // R2 R4
      {5'd19, 8'h7E, 5'd0,  8'h34},  // R3 R4
      {5'd31, 8'hFF, 5'd1,  8'hFF},  // R10 R4
      {5'd12, 8'hFF, 5'd4,  8'h08},  // R10 R4
      {5'd5,  8'h01, 5'd7,  8'hA4},  // R7
      {5'd7,  8'hFF, 5'd7,  8'hA4},  // R7 write ignored
      {5'd9,  8'h5A, 5'd9,  8'h5A},  // R5
      {5'd6,  8'h00, 5'd19, 8'h1E},  // R4
      {5'd16, 8'hFF, 5'd5,  8'h01},  // R3 R7
      {5'd20, 8'h01, 5'd0,  8'h35},  // R3
      {5'd31, 8'h00, 5'd1,  8'hEF},  // R3 only pin4 cleared
      {5'd31, 8'h00, 5'd16, 8'h7F},  // R3 R7
      {5'd31, 8'h00, 5'd12, 8'h00}   // R10
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr2(input logic wa, input logic [4:0] aa, input logic [7:0] da,
                      input logic wb, input logic [4:0] ab, input logic [7:0] db);
      @(negedge clk);
      a_we = wa; a_addr = aa; a_wdata = da;
      b_we = wb; b_addr = ab; b_wdata = db;
      @(posedge clk);
      @(negedge clk);
      a_we = 1'b0; b_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [4:0] ad, input logic [7:0] exp);
      rd_addr = ad;
      #1;
      chk(req, rd_data, exp);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog got=%0d exp=done", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int a = 0; a < 32; a++) begin
         if (a == 7) rd_chk("R1", 5'(a), 8'hA5);
         else if (a >= 16 && a < 24) rd_chk("R1", 5'(a), {pad_in[a-16], 7'h00});
         else rd_chk("R1", 5'(a), 8'h00);
      end
      chk("R1 mode", pad_mode, 24'h0);

      for (int i = 0; i < 14; i++) begin
         wr2(1'b1, VEC[i][25:21], VEC[i][20:13], 1'b0, 5'd0, 8'h00);
         rd_chk("R2-table", VEC[i][12:8], VEC[i][7:0]);
      end

      // R11: outputs follow stored bits
      chk("R11 out", pad_out, 8'h35);
      chk("R11 slow", pad_slow, 8'h09);
      chk("R11 idis", pad_in_dis, 8'h01);
      // R6: pin0 bidir mode 7 on line 0; pin3 plain mode 7
      aux_oe = 16'h0000; #1;
      chk("R6 pin0 low", pad_mode[2:0], 3'd0);
      chk("R6 pin3", pad_mode[11:9], 3'd7);
      aux_oe = 16'h0001; #1;
      chk("R6 pin0 high", pad_mode[2:0], 3'd7);
      // R5: pin2 routed from line 10
      wr2(1'b1, 5'd18, 8'h4F, 1'b0, 5'd0, 8'h00);
      aux_oe = 16'h0400; #1;
      chk("R5 pin2 line10", pad_mode[8:6], 3'd7);
      chk("R6 pin0 off", pad_mode[2:0], 3'd0);
      aux_oe = 16'h0001; #1;
      chk("R5 pin2 off", pad_mode[8:6], 3'd0);

      // R8: per-pin write beats attribute write, channels either way
      wr2(1'b1, 5'd0, 8'h00, 1'b1, 5'd21, 8'h01);
      rd_chk("R8 b pin", 5'd0, 8'h20);
      wr2(1'b1, 5'd23, 8'h01, 1'b1, 5'd0, 8'h00);
      rd_chk("R8 a pin", 5'd0, 8'h80);
      // R9: channel B wins among equals
      wr2(1'b1, 5'd4, 8'hFF, 1'b1, 5'd4, 8'h0F);
      rd_chk("R9 port", 5'd4, 8'h0F);
      wr2(1'b1, 5'd22, 8'h10, 1'b1, 5'd22, 8'h00);
      rd_chk("R9 pin", 5'd22, 8'h00);
      wr2(1'b1, 5'd8, 8'h21, 1'b1, 5'd8, 8'h43);
      rd_chk("R9 sel", 5'd8, 8'h43);
      // R10: write to unmapped range leaves everything unchanged
      wr2(1'b1, 5'd13, 8'hFF, 1'b1, 5'd27, 8'hFF);
      rd_chk("R10 port", 5'd4, 8'h0F);
      rd_chk("R10 read", 5'd27, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule